// File: doc/BRIEF.md
# Shared Timer Prescaler with Per-Channel Clock Select

This block produces the count-enable strobes for a pair of timer channels. A single free-running binary divider, shared by both channels, advances on every system clock. Each channel has its own 3-bit select code. The code picks where that channel's single-cycle count-enable comes from:

- nothing (the channel is stopped),
- every system clock,
- one of four divider taps (divide by 8, 64, 256 or 1024),
- an externally supplied falling-edge pulse,
- an externally supplied rising-edge pulse.

The divider runs whatever either channel selects. A synchronous divider-clear input restarts the divide period for every channel at once. Software uses this clear to line up timer ticks with program events. The clear also moves the tick phase of the other channel.

The external edge pulses reach the block already synchronized and edge-detected. The block passes them through in the same cycle. The timer counters themselves sit outside this block. They use `cnt_en_o` as their increment enable.

Top module: `tmr_clk_select`

## Requirements
- R1: While `rst_n_i` is low, every `cnt_en_o` bit is 0 whatever the selects and edge inputs are. The divider leaves reset at 0 and holds 1 in the first cycle after the first clock edge following release.
- R2: Select code 0 stops a channel: its `cnt_en_o` bit stays 0 for all divider states and edge inputs.
- R3: Select code 1 asserts the channel's `cnt_en_o` in every cycle.
- R4: Select codes 2, 3, 4 and 5 give divisors 8, 64, 256 and 1024. The strobe is high for exactly one cycle, when the low 3, 6, 8 or 10 bits of the divider are all ones, so successive strobes are exactly N cycles apart.
- R5: The 10-bit divider counts up by one every cycle and wraps from 1023 to 0. Its phase does not depend on either channel's select code.
- R6: When `psc_clr_i` is high in a cycle, the divider holds 0 in the next cycle. For every channel on a prescaled select, the next strobe then comes N−1 cycles after that cycle (where the divider equals N−1), with period N afterwards.
- R7: Select code 6 passes the channel's `ext_fall_i` bit to `cnt_en_o` in the same cycle, and code 7 passes `ext_rise_i`. The other edge input of that channel has no effect.
- R8: After a channel changes to a prescaled select, its first strobe arrives no later than N−1 cycles after the cycle in which the new code is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| psc_clr_i | input | 1 | Synchronous clear of the shared divider |
| ch_sel_i | input | 6 | Select codes, channel c in bits [3c+2:3c] |
| ext_rise_i | input | 2 | Rising-edge pulse per channel, already synchronized |
| ext_fall_i | input | 2 | Falling-edge pulse per channel, already synchronized |
| cnt_en_o | output | 2 | Per-channel single-cycle count-enable strobe |

## Verification
The divider has no visible output, so its phase can only be inferred from tap strobes. The hardest case is to show that a tap strobe lands at a known cycle relative to a select change or a clear, while the other channel is on a different divisor. The stimulus gets there by pulsing the divider clear to pin the phase to a known count. It then switches selects at chosen offsets, including just after a tap has fired, and toggles the other channel's code freely. Finally it compares both channels' strobes cycle by cycle against the counts predicted from that clear, across a full 1024-cycle wrap.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int SEL_W  = 3;
   localparam int N_TAPS = 4;

   typedef enum logic [SEL_W-1:0] {
      SEL_OFF   = 3'd0,
      SEL_SYS   = 3'd1,
      SEL_D8    = 3'd2,
      SEL_D64   = 3'd3,
      SEL_D256  = 3'd4,
      SEL_D1024 = 3'd5,
      SEL_FALL  = 3'd6,
      SEL_RISE  = 3'd7
   } tcs_sel_e;

   // number of low divider bits that must be all ones for tap idx
   function automatic int tap_bits(input int idx);
      case (idx)
         0:       tap_bits = 3;
         1:       tap_bits = 6;
         2:       tap_bits = 8;
         default: tap_bits = 10;
      endcase
   endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
   parameter int CNT_W  = 10,
   parameter int N_TAPS = tcs_pkg::N_TAPS
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              clr_i,
   output logic [N_TAPS-1:0] tap_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   generate
      if (tcs_pkg::tap_bits(N_TAPS-1) > CNT_W) begin : g_bad_width
         $error("tcs_prescaler: CNT_W too small for widest tap");
      end
      if (N_TAPS < 1) begin : g_bad_taps
         $error("tcs_prescaler: need at least one tap");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   generate
      for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
         localparam int LB = tcs_pkg::tap_bits(k);
         assign tap_o[k] = &cnt_q[LB-1:0];

         // R4: a tap is a single-cycle strobe
         a_r4_tap_single : assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (tap_o[k] && !clr_i) |=> !tap_o[k]);
      end
   endgenerate

   // R6: clear forces the divider to zero on the next cycle
   a_r6_clear_zero : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      clr_i |=> (cnt_q == '0));

   // R5: wrap from the top count back to zero
   a_r5_wrap : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!clr_i && cnt_q == CNT_TOP) |=> (cnt_q == '0));

   // R5: wider taps only fire together with narrower ones
   a_r5_tap_nesting : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      tap_o[N_TAPS-1] |-> (&tap_o));

endmodule

// File: rtl/tcs_chan_sel.sv
module tcs_chan_sel #(
   parameter int N_TAPS = tcs_pkg::N_TAPS
) (
   input  logic                     run_i,
   input  logic [tcs_pkg::SEL_W-1:0] sel_i,
   input  logic [N_TAPS-1:0]        tap_i,
   input  logic                     rise_i,
   input  logic                     fall_i,
   output logic                     en_o
);
   import tcs_pkg::*;

   generate
      if (N_TAPS != 4) begin : g_bad_taps
         $error("tcs_chan_sel: select decode expects four taps");
      end
   endgenerate

   logic pick;

   always_comb begin
      unique case (tcs_sel_e'(sel_i))
         SEL_OFF:   pick = 1'b0;
         SEL_SYS:   pick = 1'b1;
         SEL_D8:    pick = tap_i[0];
         SEL_D64:   pick = tap_i[1];
         SEL_D256:  pick = tap_i[2];
         SEL_D1024: pick = tap_i[3];
         SEL_FALL:  pick = fall_i;
         SEL_RISE:  pick = rise_i;
         default:   pick = 1'b0;
      endcase
   end

   assign en_o = run_i & pick;

endmodule

// File: rtl/tmr_clk_select.sv
module tmr_clk_select #(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 10
) (
   input  logic                             clk_i,
   input  logic                             rst_n_i,
   input  logic                             psc_clr_i,
   input  logic [NUM_CH*tcs_pkg::SEL_W-1:0] ch_sel_i,
   input  logic [NUM_CH-1:0]                ext_rise_i,
   input  logic [NUM_CH-1:0]                ext_fall_i,
   output logic [NUM_CH-1:0]                cnt_en_o
);
   import tcs_pkg::*;

   localparam int SW = SEL_W;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("tmr_clk_select: NUM_CH must be at least 1");
      end
   endgenerate

   logic [N_TAPS-1:0] taps;

   tcs_prescaler #(
      .CNT_W  (CNT_W),
      .N_TAPS (N_TAPS)
   ) u_prescaler (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .clr_i   (psc_clr_i),
      .tap_o   (taps)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [SW-1:0] sel;
         assign sel = ch_sel_i[c*SW +: SW];

         tcs_chan_sel #(
            .N_TAPS (N_TAPS)
         ) u_sel (
            .run_i  (rst_n_i),
            .sel_i  (sel),
            .tap_i  (taps),
            .rise_i (ext_rise_i[c]),
            .fall_i (ext_fall_i[c]),
            .en_o   (cnt_en_o[c])
         );

         // R2: stopped channel is silent
         a_r2_off_silent : assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (sel == SEL_OFF) |-> !cnt_en_o[c]);
         // R3: system-clock select strobes every cycle
         a_r3_sys_every : assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (sel == SEL_SYS) |-> cnt_en_o[c]);
         // R7: edge selects follow their own edge pulse only
         a_r7_fall_pass : assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (sel == SEL_FALL) |-> (cnt_en_o[c] == ext_fall_i[c]));
         a_r7_rise_pass : assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (sel == SEL_RISE) |-> (cnt_en_o[c] == ext_rise_i[c]));
         // R4: prescaled selects never strobe two cycles running
         a_r4_div_gap : assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (sel >= SEL_D8 && sel <= SEL_D1024 && $stable(sel) && !psc_clr_i && cnt_en_o[c])
               |=> ($changed(sel) || !cnt_en_o[c]));
      end
   endgenerate

   // R1: nothing strobes while reset is held
   always_comb begin
      if (!rst_n_i) begin
         a_r1_quiet_in_reset : assert (cnt_en_o == '0);
      end
   end

endmodule

// File: tb/tmr_clk_select_bench.sv
module tmr_clk_select_bench;

   localparam int NCH = 2;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           clr;
   logic [NCH*3-1:0] sel;
   logic [NCH-1:0] rise;
   logic [NCH-1:0] fall;
   logic [NCH-1:0] en;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   tmr_clk_select #(.NUM_CH(NCH), .CNT_W(10)) u_tmr_clk_select (
      .clk_i      (clk),
      .rst_n_i    (rst_n),
      .psc_clr_i  (clr),
      .ch_sel_i   (sel),
      .ext_rise_i (rise),
      .ext_fall_i (fall),
      .cnt_en_o   (en)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_sel(input int ch, input logic [2:0] code);
      sel[ch*3 +: 3] = code;
   endtask

   function automatic int divisor(input logic [2:0] code);
      case (code)
         3'd2:    return 8;
         3'd3:    return 64;
         3'd4:    return 256;
         3'd5:    return 1024;
         default: return 0;
      endcase
   endfunction

   // pulse the divider clear; on return the divider is 0 in the current cycle
   task automatic pulse_clear();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   // R1: quiet in reset, divider starts from zero
   task automatic t_reset();
      rst_n = 1'b0; clr = 1'b0;
      set_sel(0, 3'd1); set_sel(1, 3'd7);
      rise = '1; fall = '1;
      repeat (4) begin
         @(negedge clk); #1;
         chk("R1 en in reset", int'(en), 0);
      end
      set_sel(0, 3'd2); set_sel(1, 3'd0);
      rise = '0; fall = '0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int j = 1; j <= 9; j++) begin
         @(negedge clk); #1;
         chk("R1 first div8 tick after release", int'(en[0]), (j == 7) ? 1 : 0);
      end
   endtask

   // R2: off never strobes
   task automatic t_off();
      set_sel(0, 3'd0); set_sel(1, 3'd0);
      for (int i = 0; i < 1100; i++) begin
         @(negedge clk);
         rise = 2'(i); fall = 2'(i >> 1); #1;
         chk("R2 off channel", int'(en), 0);
      end
      rise = '0; fall = '0;
   endtask

   // R3: every cycle
   task automatic t_sys();
      set_sel(0, 3'd1); set_sel(1, 3'd1);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); #1;
         chk("R3 sys every cycle", int'(en), 3);
      end
   endtask

   // R4/R6: exact strobe positions after a clear, both channels together
   task automatic tap_run(input logic [2:0] c0, input logic [2:0] c1, input int span,
                          input string req);
      int n0, n1;
      n0 = divisor(c0); n1 = divisor(c1);
      set_sel(0, c0); set_sel(1, c1);
      pulse_clear();
      for (int i = 0; i < span; i++) begin
         if (i > 0) @(negedge clk);
         #1;
         chk({req, " ch0"}, int'(en[0]), ((i % n0) == n0 - 1) ? 1 : 0);
         chk({req, " ch1"}, int'(en[1]), ((i % n1) == n1 - 1) ? 1 : 0);
      end
   endtask

   task automatic t_taps();
      tap_run(3'd2, 3'd3, 200,  "R4 div8/div64");
      tap_run(3'd5, 3'd4, 2100, "R4 R5 div1024/div256 with wrap");
   endtask

   // R6: clear at an arbitrary phase realigns both channels
   task automatic t_realign();
      set_sel(0, 3'd2); set_sel(1, 3'd4);
      repeat (37) @(negedge clk);
      tap_run(3'd2, 3'd4, 600, "R6 realign");
      set_sel(0, 3'd3); set_sel(1, 3'd2);
      repeat (19) @(negedge clk);
      tap_run(3'd3, 3'd2, 150, "R6 realign swapped");
   endtask

   // R7: edge pulses
   task automatic t_edges();
      set_sel(0, 3'd6); set_sel(1, 3'd7);
      @(negedge clk); rise = 2'b11; fall = 2'b00; #1;
      chk("R7 rise only: fall ch ignores", int'(en[0]), 0);
      chk("R7 rise only: rise ch passes",  int'(en[1]), 1);
      @(negedge clk); rise = 2'b00; fall = 2'b11; #1;
      chk("R7 fall only: fall ch passes",  int'(en[0]), 1);
      chk("R7 fall only: rise ch ignores", int'(en[1]), 0);
      @(negedge clk); rise = 2'b11; fall = 2'b11; #1;
      chk("R7 both", int'(en), 3);
      @(negedge clk); rise = 2'b00; fall = 2'b00; #1;
      chk("R7 none", int'(en), 0);
      @(negedge clk); rise = 2'b01; fall = 2'b10; #1;
      chk("R7 mixed", int'(en), 0);
      @(negedge clk); rise = 2'b10; fall = 2'b01; #1;
      chk("R7 mixed swap", int'(en), 3);
      @(negedge clk); rise = '0; fall = '0;
   endtask

   // R5/R8: divider phase ignores selects; first strobe latency bounded
   task automatic t_free_run();
      int first0, first1, relock;
      logic [2:0] spin [4] = '{3'd1, 3'd6, 3'd7, 3'd0};
      first0 = -1; first1 = -1; relock = -1;
      set_sel(0, 3'd0); set_sel(1, 3'd0);
      pulse_clear();
      for (int i = 0; i < 130; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 5)  set_sel(0, 3'd2);
         if (i == 30) set_sel(0, 3'd0);
         if (i == 40) set_sel(0, 3'd2);
         if (i < 8)   set_sel(1, spin[i % 4]);
         if (i == 8)  set_sel(1, 3'd3);
         #1;
         if (i >= 5 && i < 30)
            chk("R5 ch0 phase unaffected by ch1", int'(en[0]), ((i % 8) == 7) ? 1 : 0);
         if (i >= 30 && i < 40)
            chk("R2 ch0 off window", int'(en[0]), 0);
         if (i >= 40)
            chk("R5 ch0 phase after reselect", int'(en[0]), ((i % 8) == 7) ? 1 : 0);
         if (i >= 8)
            chk("R5 ch1 phase from clear", int'(en[1]), ((i % 64) == 63) ? 1 : 0);
         if (i >= 5 && i < 30 && en[0] && first0 < 0) first0 = i - 5;
         if (i >= 40 && en[0] && relock < 0)          relock = i - 40;
         if (i >= 8 && en[1] && first1 < 0)           first1 = i - 8;
      end
      chk("R8 ch0 first latency", first0, 2);
      chk("R8 ch0 relock latency", relock, 7);
      chk("R8 ch1 latency within N-1", int'(first1 >= 0 && first1 <= 63), 1);
   endtask

   initial begin
      rst_n = 1'b0; clr = 1'b0; sel = '0; rise = '0; fall = '0;
      t_reset();
      t_off();
      t_sys();
      t_taps();
      t_realign();
      t_edges();
      t_free_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule